// File: doc/BRIEF.md
# Transport Stream Packet PID Filter

The block receives transport stream packets one byte per cycle, with a start marker on the first byte of each packet. Every packet is 188 bytes long. Each packet is written whole into an internal store. When the last byte arrives, the four header bytes decide whether the packet goes out. A packet is forwarded only if all of these hold:

- its first byte is the sync value 0x47;
- its transport error flag is clear;
- its PID is not the null PID;
- its PID equals an enabled entry of a small PID table that can be written at any time.

A forwarded packet is replayed as one unbroken burst, with start and end markers. The decoded header fields are held steady beside it for the whole burst. A rejected packet produces no output at all. A start marker that cuts a packet short abandons that packet, counts an error, and begins a new packet.

The store has two packet-sized banks. One packet can play out while the next one fills, so the block keeps up with an input that never pauses.

Top module: `ts_pid_filter`

## Requirements
- R1: A forwarded packet appears on the output as 188 consecutive valid cycles. `out_sop` is high on the first cycle only and `out_eop` on the last cycle only. The bytes are identical to the input bytes and in the same order.
- R2: A packet whose byte 0 is not 0x47 produces no output.
- R3: A packet with byte 1 bit 7 (transport error) set produces no output.
- R4: The PID is {byte1[4:0], byte2}. A packet with PID 0x1FFF produces no output, even when a table entry holds 0x1FFF.
- R5: The table has 16 entries. A cycle with `tbl_we` high writes `tbl_pid` and `tbl_en` into entry `tbl_addr`. A valid packet is forwarded only if some entry is enabled and holds its PID. A disabled entry never matches.
- R6: During a forwarded packet the sideband fields hold constant values. `out_pid` is the PID, `out_pusi` is byte1[6] and `out_prio` is byte1[5]. `out_scr` is byte3[7:6], `out_afc` is byte3[5:4] and `out_cc` is byte3[3:0].
- R7: A dropped packet leaves `out_valid` low for its whole duration.
- R8: An `in_sop` that arrives after at least one byte of an unfinished packet abandons that packet and increments `err_count` by one (saturating). The marked byte becomes byte 0 of a new packet.
- R9: While no packet is open, input bytes without `in_sop` are ignored.
- R10: The first output byte appears one cycle after the edge that captures a kept packet's last byte. Packets received back to back are forwarded with no idle cycle between them.
- R11: After reset `out_valid` is low, `err_count` is zero and every table entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| in_data | input | 8 | Input byte |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry index |
| tbl_pid | input | 13 | PID to store |
| tbl_en | input | 1 | Enable bit to store |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | First byte of forwarded packet |
| out_eop | output | 1 | Last byte of forwarded packet |
| out_data | output | 8 | Output byte |
| out_pid | output | 13 | PID of current output packet |
| out_pusi | output | 1 | Payload unit start flag |
| out_prio | output | 1 | Transport priority flag |
| out_scr | output | 2 | Scrambling control |
| out_afc | output | 2 | Adaptation field control |
| out_cc | output | 4 | Continuity counter |
| err_count | output | 16 | Count of abandoned packets |

## Verification
The bench builds the block with its defaults: 188-byte packets, 16 table entries, a 13-bit PID and a 16-bit error counter.

- The real packet length lets it check the exact 187-cycle span from `out_sop` to `out_eop`.
- It checks the gapless hand-over between the two banks when packets arrive back to back.
- It uses the full 16-entry table, so both index 0 and index 15 are tried as matching entries.
- It writes the null PID into the table to confirm that the null check wins over a table match.

// File: rtl/ts_pid_filter.sv
module ts_pid_filter #(
  parameter int PKT_LEN = 188,
  parameter int TBL_N   = 16,
  parameter int PID_W   = 13,
  parameter int ERR_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic [7:0]               in_data,
  input  logic                     tbl_we,
  input  logic [$clog2(TBL_N)-1:0] tbl_addr,
  input  logic [PID_W-1:0]         tbl_pid,
  input  logic                     tbl_en,
  output logic                     out_valid,
  output logic                     out_sop,
  output logic                     out_eop,
  output logic [7:0]               out_data,
  output logic [PID_W-1:0]         out_pid,
  output logic                     out_pusi,
  output logic                     out_prio,
  output logic [1:0]               out_scr,
  output logic [1:0]               out_afc,
  output logic [3:0]               out_cc,
  output logic [ERR_W-1:0]         err_count
);
  localparam int CW = $clog2(PKT_LEN);
  localparam int MW = $clog2(2 * PKT_LEN);
  localparam logic [CW-1:0] LAST = CW'(PKT_LEN - 1);

  logic [7:0]       mem [2*PKT_LEN];
  logic [PID_W-1:0] t_pid [TBL_N];
  logic [TBL_N-1:0] t_en;

  logic          rx_act, wr_bank, play, rd_bank;
  logic [CW-1:0] wr_cnt, rd_cnt;
  logic [7:0]    h0, h1, h2, h3;

  logic [PID_W-1:0] p_pid;
  logic             p_pusi, p_prio;
  logic [1:0]       p_scr, p_afc;
  logic [3:0]       p_cc;

  wire              take  = in_valid && (in_sop || rx_act);
  wire [CW-1:0]     wi    = in_sop ? '0 : wr_cnt;
  wire              last  = take && !in_sop && (wr_cnt == LAST);
  wire [PID_W-1:0]  pid_w = PID_W'({h1[4:0], h2});
  wire [MW-1:0]     wa    = MW'(wi) + (wr_bank ? MW'(PKT_LEN) : MW'(0));
  wire [MW-1:0]     ra    = MW'(rd_cnt) + (rd_bank ? MW'(PKT_LEN) : MW'(0));

  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < TBL_N; i++)
      if (t_en[i] && t_pid[i] == pid_w) hit = 1'b1;
  end

  wire keep   = (h0 == 8'h47) && !h1[7] && (pid_w != '1) && hit;
  wire launch = last && keep;

  // PID table
  always_ff @(posedge clk) begin
    if (!rst_n) t_en <= '0;
    else if (tbl_we) t_en[tbl_addr] <= tbl_en;
  end

  always_ff @(posedge clk)
    if (tbl_we) t_pid[tbl_addr] <= tbl_pid;

  // packet store
  always_ff @(posedge clk) begin
    if (take) mem[wa] <= in_data;
    out_data <= mem[ra];
  end

  // receive side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_act    <= 1'b0;
      wr_cnt    <= '0;
      wr_bank   <= 1'b0;
      err_count <= '0;
      h0 <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
    end else if (take) begin
      if (in_sop) begin
        if (rx_act && err_count != '1) err_count <= err_count + 1'b1;
        rx_act <= 1'b1;
        wr_cnt <= CW'(1);
        h0     <= in_data;
      end else begin
        case (wr_cnt)
          CW'(1): h1 <= in_data;
          CW'(2): h2 <= in_data;
          CW'(3): h3 <= in_data;
          default: ;
        endcase
        if (last) begin
          rx_act <= 1'b0;
          wr_cnt <= '0;
          if (keep) wr_bank <= ~wr_bank;
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end
    end
  end

  // playout side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play    <= 1'b0;
      rd_cnt  <= '0;
      rd_bank <= 1'b0;
      p_pid <= '0; p_pusi <= 1'b0; p_prio <= 1'b0;
      p_scr <= '0; p_afc <= '0; p_cc <= '0;
    end else if (launch) begin
      play    <= 1'b1;
      rd_cnt  <= '0;
      rd_bank <= wr_bank;
      p_pid   <= pid_w;
      p_pusi  <= h1[6];
      p_prio  <= h1[5];
      p_scr   <= h3[7:6];
      p_afc   <= h3[5:4];
      p_cc    <= h3[3:0];
    end else if (play) begin
      if (rd_cnt == LAST) play <= 1'b0;
      else rd_cnt <= rd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_pid <= '0; out_pusi <= 1'b0; out_prio <= 1'b0;
      out_scr <= '0; out_afc <= '0; out_cc <= '0;
    end else begin
      out_valid <= play;
      out_sop   <= play && rd_cnt == '0;
      out_eop   <= play && rd_cnt == LAST;
      if (play && rd_cnt == '0) begin
        out_pid  <= p_pid;
        out_pusi <= p_pusi;
        out_prio <= p_prio;
        out_scr  <= p_scr;
        out_afc  <= p_afc;
        out_cc   <= p_cc;
      end
    end
  end

  AST_SOP_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid && out_data == 8'h47); // R2
  AST_NO_NULL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_pid != '1); // R4
  AST_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |=> out_valid && !out_sop); // R1
  AST_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> !out_valid || out_sop); // R10
  AST_HDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |=> $stable(out_pid) && $stable(out_cc) && $stable(out_afc)); // R6
  AST_ERR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    err_count >= $past(err_count)); // R8
  AST_MARKS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_sop && !out_eop); // R7
endmodule

// File: tb/ts_pid_filter_tb.sv
`timescale 1ns/1ps
module ts_pid_filter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, tbl_we = 0, tbl_en = 0;
  logic [7:0] in_data = '0;
  logic [3:0] tbl_addr = '0;
  logic [12:0] tbl_pid = '0;
  logic out_valid, out_sop, out_eop, out_pusi, out_prio;
  logic [7:0] out_data;
  logic [12:0] out_pid;
  logic [1:0] out_scr, out_afc;
  logic [3:0] out_cc;
  logic [15:0] err_count;

  ts_pid_filter u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int cap_n = 0, pk_n = 0, hdr_bad = 0;
  logic [7:0] cap [4096];
  int sop_c [32], eop_c [32];
  logic [12:0] m_pid; logic m_pusi, m_prio; logic [1:0] m_scr, m_afc; logic [3:0] m_cc;

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n && out_valid) begin
    if (cap_n < 4096) cap[cap_n] = out_data;
    cap_n++;
    if (out_sop) begin
      if (pk_n < 32) sop_c[pk_n] = cyc;
      pk_n++;
      m_pid = out_pid; m_pusi = out_pusi; m_prio = out_prio;
      m_scr = out_scr; m_afc = out_afc; m_cc = out_cc;
    end else if (out_pid != m_pid || out_pusi != m_pusi || out_prio != m_prio ||
                 out_scr != m_scr || out_afc != m_afc || out_cc != m_cc) hdr_bad++;
    if (out_eop && pk_n > 0 && pk_n <= 32) eop_c[pk_n-1] = cyc;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(int i, logic [7:0] b0, b1, b2, b3, int seed);
    case (i)
      0: return b0; 1: return b1; 2: return b2; 3: return b3;
      default: return 8'(seed + i * 3);
    endcase
  endfunction

  int last_cyc;
  task automatic send(logic [7:0] b0, b1, b2, b3, int seed, int n, bit mark);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = mark && i == 0; in_data = pb(i, b0, b1, b2, b3, seed);
      last_cyc = cyc;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk); in_valid = 0; in_sop = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic tw(int a, int pid, bit en);
    @(negedge clk); tbl_we = 1; tbl_addr = 4'(a); tbl_pid = 13'(pid); tbl_en = en;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic check_bytes(string tag, int base, logic [7:0] b0, b1, b2, b3, int seed);
    int bad = 0;
    for (int i = 0; i < 188; i++) if (cap[base + i] != pb(i, b0, b1, b2, b3, seed)) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic expect_drop(string tag, logic [7:0] b0, b1, b2, b3);
    int c0 = cap_n;
    send(b0, b1, b2, b3, 11, 188, 1); idle(200);
    chk(tag, cap_n - c0, 0);
  endtask

  task automatic t_reset();
    chk("R11 out_valid", int'(out_valid), 0);
    chk("R11 err_count", int'(err_count), 0);
    expect_drop("R11 empty table", 8'h47, 8'h01, 8'h00, 8'h10);
  endtask

  task automatic t_pass();
    int c0 = cap_n, p0 = pk_n;
    send(8'h47, 8'h41, 8'h00, 8'h97, 5, 188, 1); idle(200);
    chk("R1 byte count", cap_n - c0, 188);
    check_bytes("R1 data", c0, 8'h47, 8'h41, 8'h00, 8'h97, 5);
    chk("R1 sop-eop span", eop_c[p0] - sop_c[p0], 187);
    chk("R10 latency", sop_c[p0] - last_cyc, 2);
    chk("R4 pid", int'(m_pid), 'h100);
    chk("R6 pusi", int'(m_pusi), 1);
    chk("R6 prio", int'(m_prio), 0);
    chk("R6 scr", int'(m_scr), 2);
    chk("R6 afc", int'(m_afc), 1);
    chk("R6 cc", int'(m_cc), 7);
    chk("R6 steady", hdr_bad, 0);
  endtask

  task automatic t_pid0();
    int c0 = cap_n;
    send(8'h47, 8'h20, 8'h00, 8'h3C, 9, 188, 1); idle(200);
    chk("R5 entry15 count", cap_n - c0, 188);
    chk("R4 pid zero", int'(m_pid), 0);
    chk("R6 prio", int'(m_prio), 1);
    chk("R6 pusi", int'(m_pusi), 0);
    chk("R6 afc", int'(m_afc), 3);
    chk("R6 cc", int'(m_cc), 12);
    chk("R6 scr", int'(m_scr), 0);
  endtask

  task automatic t_abort();
    int c0 = cap_n, e0 = int'(err_count);
    send(8'h47, 8'h01, 8'h00, 8'h10, 20, 50, 1);
    send(8'h47, 8'h01, 8'h00, 8'h11, 33, 188, 1); idle(200);
    chk("R8 err +1", int'(err_count) - e0, 1);
    chk("R8 one packet", cap_n - c0, 188);
    check_bytes("R8 new packet data", c0, 8'h47, 8'h01, 8'h00, 8'h11, 33);
  endtask

  task automatic t_stray();
    int c0 = cap_n, e0 = int'(err_count);
    send(8'h47, 8'h01, 8'h00, 8'h12, 70, 10, 0);
    send(8'h47, 8'h01, 8'h00, 8'h13, 44, 188, 1); idle(200);
    chk("R9 count", cap_n - c0, 188);
    chk("R9 no error", int'(err_count), e0);
    check_bytes("R9 data", c0, 8'h47, 8'h01, 8'h00, 8'h13, 44);
  endtask

  task automatic t_b2b();
    int c0 = cap_n, p0 = pk_n;
    send(8'h47, 8'h01, 8'h00, 8'h14, 1, 188, 1);
    send(8'h47, 8'h40, 8'h00, 8'h15, 2, 188, 1); idle(200);
    chk("R10 total", cap_n - c0, 376);
    chk("R10 gapless", sop_c[p0+1] - eop_c[p0], 1);
    check_bytes("R10 first", c0, 8'h47, 8'h01, 8'h00, 8'h14, 1);
    check_bytes("R10 second", c0 + 188, 8'h47, 8'h40, 8'h00, 8'h15, 2);
    chk("R6 second cc", int'(m_cc), 5);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    tw(0, 'h100, 1); tw(15, 'h000, 1); tw(1, 'h1FFF, 1);
    tw(5, 'hABC, 1); tw(5, 'hABC, 0);
    t_pass();
    t_pid0();
    expect_drop("R2 bad sync", 8'h46, 8'h01, 8'h00, 8'h10);
    expect_drop("R3 error flag", 8'h47, 8'h81, 8'h00, 8'h10);
    expect_drop("R4 null pid", 8'h47, 8'h1F, 8'hFF, 8'h10);
    expect_drop("R5 no match", 8'h47, 8'h02, 8'h00, 8'h10);
    expect_drop("R5 disabled entry", 8'h47, 8'h0A, 8'hBC, 8'h10);
    expect_drop("R7 silent drop", 8'h47, 8'h03, 8'h33, 8'h10);
    t_abort();
    t_stray();
    t_b2b();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule